// File: doc/BRIEF.md
# Three-Layer Accelerator Sequencer

This block steers a small neural-network accelerator through a fixed schedule of two convolution layers followed by one fully connected layer. It raises one phase enable at a time toward the datapath. The datapath answers with a one-cycle `layer_done` pulse when a layer has finished its work, and the sequencer then moves on. Once the fully connected layer finishes, the block raises `done` for one cycle.

A 2-bit mode input picks how the schedule is driven. Automatic mode runs all three layers back to back. Manual mode starts on an external step strobe and waits for a further strobe between layers. Configuration mode runs one layer chosen by an input. Test mode freezes the sequencer at once; leaving test mode continues from the frozen point. Internal state can be read at any time through a small registered address/data debug port.

Top module: `layer_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `phase_en`=0, `layer_sel`=0, `done`=0, and the debug port reads 0.
- R2: The mode encoding is 00 manual, 01 automatic, 10 configuration and 11 test. A new mode is adopted only when a run starts from idle. Test mode is the exception: it acts as soon as it is applied.
- R3: In automatic mode, `start` while idle begins a run. `phase_en` bit 0 (conv 1) is high with `layer_sel`=0, then bit 1 (conv 2) with `layer_sel`=1, then bit 2 (fully connected) with `layer_sel`=2. Each `layer_done` moves the run one step along, and without `layer_done` the current phase stays as it is.
- R4: A `layer_done` accepted in the fully connected phase ends the run. `busy` falls, and `done` is high for exactly the one following cycle.
- R5: In manual mode, `step` while idle begins at conv 1. After a non-final layer completes, `phase_en` drops to 0 and `layer_sel` shows the next layer. That layer starts on the next `step`. A `step` while a phase is enabled has no effect.
- R6: In configuration mode, `cfg_go` while idle runs only the layer given by `cfg_layer` (0, 1 or 2) and then returns to idle. `done` pulses only if that layer is the fully connected one. `cfg_layer`=3 is ignored.
- R7: Changing `mode` to manual or configuration during a run does not alter that run's sequencing.
- R8: While `mode`=11, `phase_en` is 0, `busy` and `layer_sel` hold their values, and `start`, `step`, `cfg_go` and `layer_done` are ignored.
- R9: Leaving test mode resumes the frozen run at the same layer. No phase is lost and none is repeated.
- R10: `dbg_data` shows the register selected by `dbg_addr` one cycle after the address is applied. Address 0 reads {2'b00, run mode[1:0], holding, busy, layer[1:0]}. Address 1 reads the count of accepted layer completions. Address 2 reads the count of completed fully connected layers. Every other address reads 0.
- R11: A `layer_done` while idle, while frozen, or while a manual run waits for `step` is not counted and does not advance the layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz target |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Operating mode select |
| start | input | 1 | Begin an automatic run |
| step | input | 1 | Manual step strobe |
| cfg_layer | input | 2 | Layer chosen in configuration mode |
| cfg_go | input | 1 | Begin a configured single-layer run |
| layer_done | input | 1 | Datapath completion pulse for the current layer |
| dbg_addr | input | 4 | Debug register address |
| layer_sel | output | 2 | Current layer index |
| phase_en | output | 3 | One-hot enable: conv 1, conv 2, fully connected |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the fully connected layer |
| dbg_data | output | 8 | Registered debug read data |

## Verification
The schedule is driven four ways. An automatic run with idle gaps between completions shows that phases advance only on `layer_done`. A manual run with early and extra strobes separates the waiting state from the active state. Configuration runs of the middle layer, the last layer and the out-of-range code show when `done` must appear and when it must not. A run frozen mid-layer, hit with completions and start strobes, and then released, checks through both the phase outputs and the debug counters that nothing advanced and nothing repeated. A mode switch during an automatic run checks that the mode latched at start is kept.

// File: rtl/layer_seq.sv
module layer_seq #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          start,
  input  logic          step,
  input  logic [1:0]    cfg_layer,
  input  logic          cfg_go,
  input  logic          layer_done,
  input  logic [AW-1:0] dbg_addr,
  output logic [1:0]    layer_sel,
  output logic [2:0]    phase_en,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] dbg_data
);
  localparam logic [1:0] M_MAN  = 2'b00;
  localparam logic [1:0] M_AUTO = 2'b01;
  localparam logic [1:0] M_CFG  = 2'b10;
  localparam logic [1:0] M_TEST = 2'b11;
  localparam logic [1:0] LAST   = 2'd2;

  logic          running, hold, done_r;
  logic [1:0]    layer, run_mode;
  logic [DW-1:0] n_layers, n_runs, dbg_q;

  wire frozen  = (mode == M_TEST);
  wire active  = running && !hold && !frozen;
  wire accept  = active && layer_done;
  wire finish  = (run_mode == M_CFG) || (layer == LAST);
  wire go_auto = (mode == M_AUTO) && start;
  wire go_man  = (mode == M_MAN) && step;
  wire go_cfg  = (mode == M_CFG) && cfg_go && (cfg_layer != 2'd3);
  wire launch  = !running && !frozen && (go_auto || go_man || go_cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      hold     <= 1'b0;
      layer    <= '0;
      run_mode <= M_MAN;
      done_r   <= 1'b0;
      n_layers <= '0;
      n_runs   <= '0;
      dbg_q    <= '0;
    end else begin
      done_r <= accept && (layer == LAST);
      if (launch) begin
        running  <= 1'b1;
        hold     <= 1'b0;
        run_mode <= mode;
        layer    <= go_cfg ? cfg_layer : 2'd0;
      end else if (accept) begin
        n_layers <= n_layers + 1'b1;
        if (layer == LAST) n_runs <= n_runs + 1'b1;
        if (finish) begin
          running <= 1'b0;
          layer   <= '0;
        end else begin
          layer <= layer + 2'd1;
          hold  <= (run_mode == M_MAN);
        end
      end else if (running && hold && !frozen && step) begin
        hold <= 1'b0;
      end
      case (dbg_addr)
        AW'(0):  dbg_q <= DW'({run_mode, hold, running, layer});
        AW'(1):  dbg_q <= n_layers;
        AW'(2):  dbg_q <= n_runs;
        default: dbg_q <= '0;
      endcase
    end
  end

  assign busy      = running;
  assign layer_sel = layer;
  assign phase_en  = active ? (3'b001 << layer) : 3'b000;
  assign done      = done_r;
  assign dbg_data  = dbg_q;

  // R3
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_en));
  // R3
  layer_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (layer_sel != $past(layer_sel))) |-> (layer_sel == $past(layer_sel) + 2'd1));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_done && phase_en[2]) |=> (done && !busy));
  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TEST) |=> ($stable(layer_sel) && $stable(busy)));
endmodule

// File: tb/layer_seq_bench.sv
module layer_seq_bench;
  logic       clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b01, cfg_layer = 0;
  logic       start = 0, step = 0, cfg_go = 0, layer_done = 0;
  logic [3:0] dbg_addr = 0;
  logic [1:0] layer_sel;
  logic [2:0] phase_en;
  logic       busy, done;
  logic [7:0] dbg_data;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  layer_seq u_layer_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .step(step),
    .cfg_layer(cfg_layer), .cfg_go(cfg_go), .layer_done(layer_done),
    .dbg_addr(dbg_addr), .layer_sel(layer_sel), .phase_en(phase_en),
    .busy(busy), .done(done), .dbg_data(dbg_data));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0; step = 0; cfg_go = 0; layer_done = 0; dbg_addr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_ld();   layer_done = 1; @(negedge clk); layer_done = 0; endtask
  task automatic pulse_start(); start = 1; @(negedge clk); start = 0; endtask
  task automatic pulse_step();  step = 1; @(negedge clk); step = 0; endtask
  task automatic pulse_go();    cfg_go = 1; @(negedge clk); cfg_go = 0; endtask

  task automatic t_reset();
    do_reset();
    check("R1 busy", busy, 0);
    check("R1 phase_en", phase_en, 0);
    check("R1 layer_sel", layer_sel, 0);
    check("R1 done", done, 0);
    check("R1 dbg", dbg_data, 0);
    mode = 2'b01;
    pulse_ld();
    dbg_addr = 1;
    @(negedge clk);
    check("R11 idle layer_done not counted", dbg_data, 0);
    check("R11 idle stays idle", busy, 0);
  endtask

  task automatic t_auto();
    do_reset();
    mode = 2'b01;
    pulse_start();
    check("R2 R3 conv1 enabled", phase_en, 1);
    check("R3 layer 0", layer_sel, 0);
    check("R3 busy", busy, 1);
    repeat (3) @(negedge clk);
    check("R3 waits for layer_done", phase_en, 1);
    pulse_ld();
    check("R3 conv2 enabled", phase_en, 2);
    check("R3 layer 1", layer_sel, 1);
    pulse_ld();
    check("R3 fc enabled", phase_en, 4);
    pulse_ld();
    check("R4 done high", done, 1);
    check("R4 busy low", busy, 0);
    check("R4 phase off", phase_en, 0);
    @(negedge clk);
    check("R4 done one cycle", done, 0);
  endtask

  task automatic t_manual();
    do_reset();
    mode = 2'b00;
    pulse_step();
    check("R2 R5 conv1 on step", phase_en, 1);
    pulse_step();
    check("R5 step while active ignored", phase_en, 1);
    pulse_ld();
    check("R5 hold phase off", phase_en, 0);
    check("R5 hold busy", busy, 1);
    check("R5 hold next layer", layer_sel, 1);
    pulse_ld();
    check("R11 ignored while holding", layer_sel, 1);
    repeat (2) @(negedge clk);
    check("R5 still holding", phase_en, 0);
    pulse_step();
    check("R5 conv2 on step", phase_en, 2);
    pulse_ld();
    pulse_step();
    check("R5 fc on step", phase_en, 4);
    pulse_ld();
    check("R5 done after fc", done, 1);
    dbg_addr = 1;
    @(negedge clk);
    check("R11 count excludes held done", dbg_data, 3);
  endtask

  task automatic t_config();
    do_reset();
    mode = 2'b10;
    cfg_layer = 3;
    pulse_go();
    check("R6 layer 3 ignored", busy, 0);
    cfg_layer = 1;
    pulse_go();
    check("R2 R6 conv2 only", phase_en, 2);
    pulse_ld();
    check("R6 back to idle", busy, 0);
    check("R6 no done for conv", done, 0);
    cfg_layer = 2;
    pulse_go();
    check("R6 fc only", phase_en, 4);
    pulse_ld();
    check("R6 done for fc", done, 1);
    check("R6 idle after fc", busy, 0);
  endtask

  task automatic t_modechg();
    do_reset();
    mode = 2'b01;
    pulse_start();
    mode = 2'b00;
    @(negedge clk);
    pulse_ld();
    check("R7 still automatic, no hold", phase_en, 2);
    mode = 2'b10;
    pulse_ld();
    check("R7 continues to fc", phase_en, 4);
    pulse_ld();
    check("R7 done", done, 1);
  endtask

  task automatic t_test();
    do_reset();
    mode = 2'b01;
    pulse_start();
    pulse_ld();
    mode = 2'b11;
    @(negedge clk);
    check("R8 phase off", phase_en, 0);
    check("R8 busy held", busy, 1);
    check("R8 layer held", layer_sel, 1);
    pulse_ld();
    check("R8 layer_done ignored", layer_sel, 1);
    pulse_start();
    pulse_step();
    check("R8 strobes ignored", layer_sel, 1);
    dbg_addr = 0;
    @(negedge clk);
    check("R10 state word", dbg_data, 8'h15);
    dbg_addr = 1;
    #1;
    check("R10 not yet updated", dbg_data, 8'h15);
    @(negedge clk);
    check("R10 R11 layer count frozen", dbg_data, 1);
    dbg_addr = 7;
    @(negedge clk);
    check("R10 unused address", dbg_data, 0);
    mode = 2'b01;
    @(negedge clk);
    check("R9 resumes conv2", phase_en, 2);
    pulse_ld();
    check("R9 then fc", phase_en, 4);
    pulse_ld();
    check("R9 done", done, 1);
    dbg_addr = 2;
    @(negedge clk);
    check("R10 run count", dbg_data, 1);
    dbg_addr = 1;
    @(negedge clk);
    check("R9 R10 no repeated layer", dbg_data, 3);
  endtask

  initial begin
    t_reset();
    t_auto();
    t_manual();
    t_config();
    t_modechg();
    t_test();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule